// File: doc/BRIEF.md
# Elastic Sample Buffer with Slip Control

This block joins an audio sample source and an audio sample sink that run on separate clocks whose nominal rates match but drift apart by a few parts per million. Samples enter on the write clock and leave on the read clock through a small dual-clock FIFO. The read side tracks how full the FIFO is and smooths that occupancy with a first-order exponential average. When the smoothed occupancy rises above an upper bound, the block throws away one whole sample. When it sinks below a lower bound, the block emits a single zero sample in place of a FIFO read. A hold-off window after each correction stops the same drift event from firing twice.

The read-side controller is a three-state machine. PRIME is the state after reset, and in it requests are ignored. The LOCK transition leaves PRIME for RUN once the measured occupancy reaches half the depth, and it loads the filter with that occupancy. In RUN, every request is served as a normal read, a drop, an insert or a hard-empty zero. A drop or insert takes the SLIP transition into HOLD, where only normal reads and hard-empty zeros are allowed. The RELEASE transition returns to RUN after the configured number of requests. The write pointer crosses into the read clock domain as Gray code through two flops. The read pointer crosses back the same way so that the write side can see when the FIFO is full.

Top module: `sample_slip_buffer`

## Requirements
- R1: While either reset is low, and on the first edges after it, rd_valid, locked, slip_drop, slip_ins, rd_underrun and wr_drop are all 0.
- R2: In PRIME a request produces no output and no event. LOCK fires on the first read edge at which the measured occupancy is at least DEPTH/2. The occupancy sees a write two read edges late, so locked is still 0 two edges after the write that reaches half full and becomes 1 on the third edge.
- R3: A normal read returns samples in the order they were written, with rd_valid high on the edge after rd_req. Every request outside PRIME yields exactly one output sample.
- R4: The filter value y has K fraction bits. LOCK loads it with level·2^K. On each served request it becomes y + ((level·2^K − y) >>> K), and then the slip adjustment is applied. fill_rate is the signed change of y across that request, and LOCK sets fill_rate to 0.
- R5: In RUN with y>>>K > hi_thr and a measured occupancy of at least 2, the request discards the oldest sample and outputs the next one. slip_drop pulses and y is lowered by 2^K.
- R6: In RUN with y>>>K < lo_thr, the request outputs 0 with rd_valid high and reads nothing from the FIFO. slip_ins pulses and y is raised by 2^K. This check takes priority over the drop check.
- R7: After a drop or insert, the next HOLDOFF requests are neither drops nor inserts, whatever the filter value.
- R8: A request that is not a slip and finds a measured occupancy of 0 outputs 0 with rd_valid high and pulses rd_underrun. It does not pulse slip_ins.
- R9: A write that finds the FIFO full (DEPTH samples, as seen by the write side) is discarded, wr_drop pulses on the next edge, and the stored samples stay unchanged.
- R10: The occupancy used by the read side is the write pointer after a two-flop Gray synchroniser minus the read pointer. With equal clocks and one write plus one read per edge, the second read after LOCK measures one less than the first, so fill_rate is −1 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Source-side clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | A sample is offered this edge |
| wr_data | input | DW | Offered sample |
| wr_drop | output | 1 | Pulse: offered sample lost because FIFO full |
| rd_clk | input | 1 | Sink-side clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_req | input | 1 | Sink asks for one sample this edge |
| hi_thr | input | AW+1 | Upper bound on filtered occupancy (whole samples) |
| lo_thr | input | AW+1 | Lower bound on filtered occupancy (whole samples) |
| rd_valid | output | 1 | rd_data carries the answer to last edge's request |
| rd_data | output | DW | Output sample |
| locked | output | 1 | Controller has left PRIME |
| slip_drop | output | 1 | Pulse: a sample was discarded by control |
| slip_ins | output | 1 | Pulse: a zero sample was inserted by control |
| rd_underrun | output | 1 | Pulse: zero output because FIFO empty |
| fill_rate | output | AW+K+3 | Signed change of the filtered level on the last request |

## Verification
The assertions assume that each reset is held for at least one edge of its own clock, that hi_thr and lo_thr change only between requests, and that HOLDOFF is at least 1. They also assume that no sample is written while the FIFO looks full, except on purpose to test the drop. The stimulus drives both sides from one clock, changes inputs only on the falling edge, and moves the thresholds only while no request is pending. Overfilling the FIFO is done once, on purpose, to check the hard-full path.

// File: rtl/slip_pkg.sv
package slip_pkg;

    typedef enum logic [1:0] {
        ST_PRIME,
        ST_RUN,
        ST_HOLD
    } slip_state_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_READ,
        ACT_DROP,
        ACT_INSERT,
        ACT_EMPTY
    } rd_act_e;

endpackage

// File: rtl/gray_ptr_sync.sv
module gray_ptr_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // each binary bit is the parity of the Gray bits at and above it
    for (genvar b = 0; b < W; b++) begin : g_bin
        assign bin_out[b] = ^(sync_q >> b);
    end
endmodule

// File: rtl/slip_ctrl.sv
module slip_ctrl
    import slip_pkg::*;
#(
    parameter int AW      = 4,
    parameter int K       = 2,
    parameter int HOLDOFF = 4,
    localparam int FW     = AW + K + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [AW:0]          level,
    input  logic [AW:0]          hi_thr,
    input  logic [AW:0]          lo_thr,
    output rd_act_e              act,
    output logic                 locked,
    output logic                 slip_drop,
    output logic                 slip_ins,
    output logic                 rd_underrun,
    output logic signed [FW-1:0] fill_rate
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int HCW   = $clog2(HOLDOFF + 1);
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
    localparam logic [PW-1:0] TWO  = PW'(2);
    localparam logic signed [FW-1:0] ONE_Q = FW'(2 ** K);

    slip_state_e state_q, state_d;
    logic [HCW-1:0] hold_q;
    logic signed [FW-1:0] y_q, y_nx, x_s, y_int, hi_s, lo_s, ema;

    assign x_s   = FW'({level, {K{1'b0}}});
    assign hi_s  = FW'(hi_thr);
    assign lo_s  = FW'(lo_thr);
    assign y_int = y_q >>> K;
    assign ema   = y_q + ((x_s - y_q) >>> K);
    assign locked = (state_q != ST_PRIME);

    // request decision: insert beats drop, both only outside hold-off
    always_comb begin
        act = ACT_IDLE;
        if (rd_req && state_q != ST_PRIME) begin
            if (state_q == ST_RUN && y_int < lo_s)
                act = ACT_INSERT;
            else if (state_q == ST_RUN && y_int > hi_s && level >= TWO)
                act = ACT_DROP;
            else if (level == '0)
                act = ACT_EMPTY;
            else
                act = ACT_READ;
        end
    end

    always_comb begin
        unique case (act)
            ACT_DROP:   y_nx = ema - ONE_Q;
            ACT_INSERT: y_nx = ema + ONE_Q;
            default:    y_nx = ema;
        endcase
    end

    // next state: LOCK, SLIP, RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PRIME: if (level >= HALF) state_d = ST_RUN;
            ST_RUN:   if (act == ACT_DROP || act == ACT_INSERT) state_d = ST_HOLD;
            ST_HOLD:  if (rd_req && hold_q == HCW'(1)) state_d = ST_RUN;
            default:  state_d = ST_PRIME;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PRIME;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q         <= '0;
            fill_rate   <= '0;
            hold_q      <= '0;
            slip_drop   <= 1'b0;
            slip_ins    <= 1'b0;
            rd_underrun <= 1'b0;
        end else begin
            slip_drop   <= (act == ACT_DROP);
            slip_ins    <= (act == ACT_INSERT);
            rd_underrun <= (act == ACT_EMPTY);
            if (state_q == ST_PRIME && state_d == ST_RUN) begin
                y_q       <= x_s;
                fill_rate <= '0;
            end else if (act != ACT_IDLE) begin
                y_q       <= y_nx;
                fill_rate <= y_nx - y_q;
            end
            if (act == ACT_DROP || act == ACT_INSERT)
                hold_q <= HCW'(HOLDOFF);
            else if (state_q == ST_HOLD && rd_req)
                hold_q <= hold_q - HCW'(1);
        end
    end

    AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_drop || slip_ins) |=> !(slip_drop || slip_ins)); // R7

    AST_LOCK_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(level) >= HALF)); // R2
endmodule

// File: rtl/sample_slip_buffer.sv
module sample_slip_buffer
    import slip_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 4,
    parameter int K       = 2,
    parameter int HOLDOFF = 4,
    localparam int FW     = AW + K + 3
) (
    input  logic                 wr_clk,
    input  logic                 wr_rst_n,
    input  logic                 wr_valid,
    input  logic [DW-1:0]        wr_data,
    output logic                 wr_drop,
    input  logic                 rd_clk,
    input  logic                 rd_rst_n,
    input  logic                 rd_req,
    input  logic [AW:0]          hi_thr,
    input  logic [AW:0]          lo_thr,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic                 locked,
    output logic                 slip_drop,
    output logic                 slip_ins,
    output logic                 rd_underrun,
    output logic signed [FW-1:0] fill_rate
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // write domain
    logic [PW-1:0] wptr_q, wgray_q, rptr_w, wptr_inc;
    logic          full;

    assign wptr_inc = wptr_q + PW'(1);
    assign full     = ((wptr_q - rptr_w) == PW'(DEPTH));

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n) begin
            wptr_q  <= '0;
            wgray_q <= '0;
            wr_drop <= 1'b0;
        end else begin
            wr_drop <= wr_valid && full;
            if (wr_valid && !full) begin
                wptr_q  <= wptr_inc;
                wgray_q <= wptr_inc ^ (wptr_inc >> 1);
            end
        end
    end

    always_ff @(posedge wr_clk) begin
        if (wr_valid && !full) mem[wptr_q[AW-1:0]] <= wr_data;
    end

    // read domain
    logic [PW-1:0] rptr_q, rptr_d, rgray_q, wptr_r, level;
    rd_act_e       act;

    assign level = wptr_r - rptr_q;

    always_comb begin
        unique case (act)
            ACT_READ: rptr_d = rptr_q + PW'(1);
            ACT_DROP: rptr_d = rptr_q + PW'(2);
            default:  rptr_d = rptr_q;
        endcase
    end

    always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n) begin
            rptr_q   <= '0;
            rgray_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rptr_q   <= rptr_d;
            rgray_q  <= rptr_d ^ (rptr_d >> 1);
            rd_valid <= (act != ACT_IDLE);
            unique case (act)
                ACT_READ: rd_data <= mem[rptr_q[AW-1:0]];
                ACT_DROP: rd_data <= mem[AW'(rptr_q[AW-1:0] + AW'(1))];
                default:  rd_data <= '0;
            endcase
        end
    end

    gray_ptr_sync #(.W(PW)) u_wsync (
        .clk(rd_clk), .rst_n(rd_rst_n), .gray_in(wgray_q), .bin_out(wptr_r)
    );

    gray_ptr_sync #(.W(PW)) u_rsync (
        .clk(wr_clk), .rst_n(wr_rst_n), .gray_in(rgray_q), .bin_out(rptr_w)
    );

    slip_ctrl #(.AW(AW), .K(K), .HOLDOFF(HOLDOFF)) u_ctrl (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_req(rd_req), .level(level),
        .hi_thr(hi_thr), .lo_thr(lo_thr), .act(act), .locked(locked),
        .slip_drop(slip_drop), .slip_ins(slip_ins), .rd_underrun(rd_underrun),
        .fill_rate(fill_rate)
    );

    AST_PRIME_SILENT: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !locked |=> !rd_valid); // R2

    AST_VALID_FOLLOWS_REQ: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        rd_valid |-> $past(rd_req)); // R3

    AST_ZERO_ON_FILL: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (slip_ins || rd_underrun) |-> (rd_valid && rd_data == '0)); // R6

    AST_WR_DROP_CAUSE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        wr_drop |-> $past(wr_valid)); // R9

    always @(posedge rd_clk) begin
        if (rd_rst_n) begin
            AST_LEVEL_BOUND: assert (level <= PW'(DEPTH)); // R10
        end
    end
endmodule

// File: tb/sim_sample_slip_buffer.sv
module sim_sample_slip_buffer;
    localparam int DW = 16, AW = 4, K = 2, HOLDOFF = 4, FW = AW + K + 3;

    typedef struct packed {
        logic [DW-1:0] wr;
        logic [DW-1:0] exp;
    } vec_t;

    // lockstep phase: write wr, expect the sample written eight places earlier
    localparam vec_t VEC [16] = '{
        '{16'h2000, 16'h1000}, '{16'h2001, 16'h1001}, '{16'h2002, 16'h1002},
        '{16'h2003, 16'h1003}, '{16'h2004, 16'h1004}, '{16'h2005, 16'h1005},
        '{16'h2006, 16'h1006}, '{16'h2007, 16'h1007}, '{16'h2008, 16'h2000},
        '{16'h2009, 16'h2001}, '{16'h200A, 16'h2002}, '{16'h200B, 16'h2003},
        '{16'h200C, 16'h2004}, '{16'h200D, 16'h2005}, '{16'h200E, 16'h2006},
        '{16'h200F, 16'h2007}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_req = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [AW:0] hi_thr = 5'd12, lo_thr = 5'd4;
    logic wr_drop, rd_valid, locked, slip_drop, slip_ins, rd_underrun;
    logic [DW-1:0] rd_data;
    logic signed [FW-1:0] fill_rate;
    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    sample_slip_buffer #(.DW(DW), .AW(AW), .K(K), .HOLDOFF(HOLDOFF)) u0 (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_drop(wr_drop), .rd_clk(clk), .rd_rst_n(rst_n), .rd_req(rd_req),
        .hi_thr(hi_thr), .lo_thr(lo_thr), .rd_valid(rd_valid), .rd_data(rd_data),
        .locked(locked), .slip_drop(slip_drop), .slip_ins(slip_ins),
        .rd_underrun(rd_underrun), .fill_rate(fill_rate)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic wv, input logic [DW-1:0] wd, input logic rq);
        wr_valid = wv;
        wr_data  = wd;
        rd_req   = rq;
        @(negedge clk);
        wr_valid = 1'b0;
        rd_req   = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "rd_valid in reset", int'(rd_valid), 0);
        check("R1", "locked in reset", int'(locked), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "events after reset",
              int'({slip_drop, slip_ins, rd_underrun, wr_drop}), 0);

        // priming
        for (int i = 0; i < 7; i++) step(1'b1, DW'(16'h1000 + i), 1'b0);
        repeat (4) step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b1);
        check("R2", "no output while priming", int'(rd_valid), 0);
        check("R2", "not locked below half", int'(locked), 0);
        step(1'b1, 16'h1007, 1'b0);
        step(1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b0);
        check("R2", "locked two edges after half write", int'(locked), 0);
        step(1'b0, '0, 1'b0);
        check("R2", "locked on third edge", int'(locked), 1);

        // table walk: one write and one read per edge
        for (int i = 0; i < 16; i++) begin
            step(1'b1, VEC[i].wr, 1'b1);
            check("R3", "lockstep valid", int'(rd_valid), 1);
            check("R3", "lockstep data", int'(rd_data), int'(VEC[i].exp));
            check("R3", "no slip in lockstep", int'({slip_drop, slip_ins}), 0);
            if (i == 0) check("R4", "rate first read", int'(fill_rate), 0);
            if (i == 1) check("R10", "rate second read", int'(fill_rate), -1);
            if (i == 2) check("R4", "rate third read", int'(fill_rate), -2);
        end

        // controlled drop
        repeat (3) step(1'b0, '0, 1'b0);
        hi_thr = 5'd3;
        step(1'b0, '0, 1'b1);
        check("R5", "slip_drop pulse", int'(slip_drop), 1);
        check("R5", "dropped oldest", int'(rd_data), 16'h2009);
        check("R5", "filter lowered", int'(fill_rate), -2);

        // hold-off: filter still above bound, no further drops
        for (int i = 0; i < HOLDOFF; i++) begin
            step(1'b0, '0, 1'b1);
            check("R7", "no slip in holdoff", int'({slip_drop, slip_ins}), 0);
            check("R7", "holdoff data", int'(rd_data), 16'h200A + i);
        end

        // controlled insert
        hi_thr = 5'd12;
        lo_thr = 5'd14;
        step(1'b0, '0, 1'b1);
        check("R6", "slip_ins pulse", int'(slip_ins), 1);
        check("R6", "inserted zero valid", int'(rd_valid), 1);
        check("R6", "inserted zero", int'(rd_data), 0);
        step(1'b0, '0, 1'b1);
        check("R6", "fifo untouched by insert", int'(rd_data), 16'h200E);
        step(1'b0, '0, 1'b1);
        check("R6", "next after insert", int'(rd_data), 16'h200F);

        // hard empty
        step(1'b0, '0, 1'b1);
        check("R8", "underrun pulse", int'(rd_underrun), 1);
        check("R8", "underrun not a slip", int'(slip_ins), 0);
        check("R8", "underrun zero", int'(rd_data), 0);

        // hard full
        lo_thr = 5'd0;
        hi_thr = 5'd31;
        for (int i = 0; i < 16; i++) step(1'b1, DW'(16'h3000 + i), 1'b0);
        check("R9", "no drop at capacity", int'(wr_drop), 0);
        step(1'b1, 16'hDEAD, 1'b0);
        check("R9", "wr_drop on full", int'(wr_drop), 1);
        repeat (3) step(1'b0, '0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            step(1'b0, '0, 1'b1);
            check("R9", "contents intact", int'(rd_data), 16'h3000 + i);
        end
        step(1'b0, '0, 1'b1);
        check("R9", "rejected sample not stored", int'(rd_underrun), 1);

        finish_run();
    end
endmodule